// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory with Overflow Policies

This block keeps the sharing state of a small set of cache lines for a 16-node shared-memory machine. It stores a few node pointers per line instead of one presence bit per node. Each entry holds two 4-bit pointers, each with its own valid bit, plus an overflow flag. A run-time policy input chooses what happens when a third distinct reader arrives. Under the broadcast policy the entry marks itself overflowed. Under the no-broadcast policy a resident sharer is displaced and must be invalidated. Under the coarse policy the pointer bits are reused as an 8-bit group vector in which each bit covers two neighbouring nodes.

Each request names a line, a node and an operation: read, write or evict. The block updates that line's entry in the same clock. One cycle later it presents the set of nodes that must be invalidated as a 16-bit node mask, together with the line number. Writes return the entry to pointer mode holding only the writer. Evictions empty the entry and invalidate every recorded sharer. Message transport and data movement are handled elsewhere.

Top module: `dir_limited_ptr`

## Requirements
- R1: After reset every entry is empty and `inv_valid` and `inv_mask` are low. A write to an empty line produces no invalidation.
- R2: A read (`req_op` = 0) from a node not yet recorded takes the lowest free pointer. A read from a node already recorded changes nothing. Neither case produces an invalidation. `req_op` = 3 is idle and leaves the entry untouched.
- R3: With `cfg_policy` = 0 (broadcast; code 3 behaves the same), a read that finds both pointers full sets the overflow flag and invalidates nothing. A later write then invalidates all 16 nodes except the writer.
- R4: With `cfg_policy` = 1 (no-broadcast), a read that finds both pointers full stores the new node in the pointer selected by a per-line round-robin index. The index starts at pointer 0 after reset, write or evict, and advances after each replacement. The displaced node alone is invalidated.
- R5: With `cfg_policy` = 2 (coarse), an overflowing read turns the entry into an 8-bit vector in which bit g stands for nodes 2g and 2g+1. The vector holds the groups of both old sharers and of the reader. Later reads set their own group bit. A write invalidates both nodes of every set group.
- R6: A write (`req_op` = 1) never invalidates the writing node.
- R7: After a write the entry is back in pointer mode with the writer as its only sharer. The next write from another node invalidates exactly the previous writer.
- R8: An evict (`req_op` = 2) invalidates every recorded sharer, with no exclusion, and leaves the entry empty.
- R9: The invalidation result appears in the clock cycle after the request. It lasts one cycle. `inv_line` returns the request's line. `inv_valid` is high exactly when the mask is non-zero.
- R10: Requests to one line never alter the state of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_policy | input | 2 | Overflow policy: 0 broadcast, 1 no-broadcast, 2 coarse, 3 as broadcast |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 idle |
| req_line | input | 2 | Line index (log2 LINES) |
| req_node | input | 4 | Requesting node (log2 NODES) |
| inv_valid | output | 1 | Invalidation mask is non-empty |
| inv_line | output | 2 | Line the mask refers to |
| inv_mask | output | 16 | One bit per node to invalidate |

## Verification
The bench builds the block with NODES = 16, NPTR = 2 and LINES = 4. Because there are only four lines, random traffic keeps returning to lines that are already shared or overflowed. Because each entry has two pointers, the third distinct reader already reaches the overflow path, so every policy's overflow branch and the round-robin victim order are hit many times. With two nodes per group, coarse writes often hit the writer's own group-mate, which tests that the writer alone is dropped from the mask. Each policy code runs from its own reset, including the reserved code 3.

// File: rtl/dir_lp_pkg.sv
package dir_lp_pkg;

   typedef enum logic [1:0] {
      POL_BCAST  = 2'd0,
      POL_NOBC   = 2'd1,
      POL_COARSE = 2'd2,
      POL_RSV    = 2'd3
   } policy_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_EVICT = 2'd2,
      OP_IDLE  = 2'd3
   } op_e;

endpackage

// File: rtl/dir_lp_expand.sv
// Turns one stored entry into a flat node mask of its sharers.
module dir_lp_expand
   import dir_lp_pkg::*;
#(
   parameter int NODES = 16,
   parameter int NPTR  = 2,
   parameter int PTR_W = 4,
   parameter int GROUP = 2
) (
   input  logic [NPTR*PTR_W-1:0] ptrs,
   input  logic [NPTR-1:0]       vld,
   input  logic                  ovf,
   input  policy_e               policy,
   output logic [NODES-1:0]      sharers
);
   localparam int GSH = $clog2(GROUP);

   logic [NODES-1:0] coarse_map;

   // Each node follows the vector bit of its group.
   for (genvar n = 0; n < NODES; n++) begin : g_coarse
      assign coarse_map[n] = ptrs[n >> GSH];
   end

   always_comb begin
      sharers = '0;
      if (!ovf) begin
         for (int p = 0; p < NPTR; p++) begin
            if (vld[p]) sharers = sharers | (NODES'(1) << ptrs[p*PTR_W +: PTR_W]);
         end
      end else if (policy == POL_COARSE) begin
         sharers = coarse_map;
      end else begin
         sharers = '1;
      end
   end
endmodule

// File: rtl/dir_lp_update.sv
// Next-state and invalidation logic for one entry and one request.
module dir_lp_update
   import dir_lp_pkg::*;
#(
   parameter int NODES = 16,
   parameter int NPTR  = 2,
   parameter int PTR_W = 4,
   parameter int CVW   = 8,
   parameter int GROUP = 2,
   parameter int RRW   = 1
) (
   input  logic [NPTR*PTR_W-1:0] cur_ptrs,
   input  logic [NPTR-1:0]       cur_vld,
   input  logic                  cur_ovf,
   input  logic [RRW-1:0]        cur_rr,
   input  op_e                   op,
   input  policy_e               policy,
   input  logic [PTR_W-1:0]      node,
   input  logic [NODES-1:0]      sharers,
   output logic [NPTR*PTR_W-1:0] nxt_ptrs,
   output logic [NPTR-1:0]       nxt_vld,
   output logic                  nxt_ovf,
   output logic [RRW-1:0]        nxt_rr,
   output logic [NODES-1:0]      inv_mask
);
   localparam int GSH = $clog2(GROUP);

   logic [CVW-1:0]   grp_bits;
   logic [CVW-1:0]   own_grp;
   logic             hit;
   logic             has_free;
   logic [RRW-1:0]   free_idx;
   logic [PTR_W-1:0] victim;

   // Collapse the current sharer mask into group bits.
   for (genvar g = 0; g < CVW; g++) begin : g_grp
      assign grp_bits[g] = |sharers[g*GROUP +: GROUP];
   end

   assign own_grp = CVW'(1) << (node >> GSH);
   assign victim  = cur_ptrs[cur_rr*PTR_W +: PTR_W];

   always_comb begin
      hit      = 1'b0;
      has_free = 1'b0;
      free_idx = '0;
      for (int p = NPTR - 1; p >= 0; p--) begin
         if (cur_vld[p] && cur_ptrs[p*PTR_W +: PTR_W] == node) hit = 1'b1;
         if (!cur_vld[p]) begin
            has_free = 1'b1;
            free_idx = RRW'(p);
         end
      end
   end

   always_comb begin
      nxt_ptrs = cur_ptrs;
      nxt_vld  = cur_vld;
      nxt_ovf  = cur_ovf;
      nxt_rr   = cur_rr;
      inv_mask = '0;
      unique case (op)
         OP_READ: begin
            if (!cur_ovf) begin
               if (!hit && has_free) begin
                  nxt_ptrs[free_idx*PTR_W +: PTR_W] = node;
                  nxt_vld[free_idx]                 = 1'b1;
               end else if (!hit) begin
                  unique case (policy)
                     POL_NOBC: begin
                        inv_mask = NODES'(1) << victim;
                        nxt_ptrs[cur_rr*PTR_W +: PTR_W] = node;
                        nxt_rr = (cur_rr == RRW'(NPTR - 1)) ? '0 : cur_rr + 1'b1;
                     end
                     POL_COARSE: begin
                        nxt_ptrs = grp_bits | own_grp;
                        nxt_ovf  = 1'b1;
                     end
                     default: nxt_ovf = 1'b1;
                  endcase
               end
            end else if (policy == POL_COARSE) begin
               nxt_ptrs = cur_ptrs | own_grp;
            end
         end
         OP_WRITE: begin
            inv_mask = sharers & ~(NODES'(1) << node);
            nxt_ptrs = (NPTR*PTR_W)'(node);
            nxt_vld  = NPTR'(1);
            nxt_ovf  = 1'b0;
            nxt_rr   = '0;
         end
         OP_EVICT: begin
            inv_mask = sharers;
            nxt_ptrs = '0;
            nxt_vld  = '0;
            nxt_ovf  = 1'b0;
            nxt_rr   = '0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dir_limited_ptr.sv
module dir_limited_ptr
   import dir_lp_pkg::*;
#(
   parameter int NODES = 16,
   parameter int NPTR  = 2,
   parameter int LINES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                cfg_policy,
   input  logic                      req_valid,
   input  logic [1:0]                req_op,
   input  logic [$clog2(LINES)-1:0]  req_line,
   input  logic [$clog2(NODES)-1:0]  req_node,
   output logic                      inv_valid,
   output logic [$clog2(LINES)-1:0]  inv_line,
   output logic [NODES-1:0]          inv_mask
);
   localparam int PTR_W  = $clog2(NODES);
   localparam int LINE_W = $clog2(LINES);
   localparam int CVW    = NPTR * PTR_W;
   localparam int GROUP  = NODES / CVW;
   localparam int RRW    = $clog2(NPTR);

   if (NODES != (1 << PTR_W)) begin : g_chk_nodes
      $error("NODES must be a power of two");
   end
   if (LINES < 2 || LINES != (1 << LINE_W)) begin : g_chk_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (NPTR < 2) begin : g_chk_nptr
      $error("NPTR must be at least 2");
   end
   if (GROUP < 1 || NODES != GROUP * CVW || GROUP != (1 << $clog2(GROUP))) begin : g_chk_group
      $error("coarse vector width must divide NODES into power-of-two groups");
   end

   logic [NPTR*PTR_W-1:0] st_ptrs [LINES];
   logic [NPTR-1:0]       st_vld  [LINES];
   logic [RRW-1:0]        st_rr   [LINES];
   logic [LINES-1:0]      st_ovf;

   policy_e               policy;
   op_e                   op;
   logic [NODES-1:0]      cur_sharers;
   logic [NPTR*PTR_W-1:0] nxt_ptrs;
   logic [NPTR-1:0]       nxt_vld;
   logic                  nxt_ovf;
   logic [RRW-1:0]        nxt_rr;
   logic [NODES-1:0]      upd_inv;
   logic                  do_req;

   assign policy = policy_e'(cfg_policy);
   assign op     = op_e'(req_op);
   assign do_req = req_valid && (op != OP_IDLE);

   dir_lp_expand #(
      .NODES(NODES), .NPTR(NPTR), .PTR_W(PTR_W), .GROUP(GROUP)
   ) u_expand (
      .ptrs    (st_ptrs[req_line]),
      .vld     (st_vld[req_line]),
      .ovf     (st_ovf[req_line]),
      .policy  (policy),
      .sharers (cur_sharers)
   );

   dir_lp_update #(
      .NODES(NODES), .NPTR(NPTR), .PTR_W(PTR_W), .CVW(CVW), .GROUP(GROUP), .RRW(RRW)
   ) u_update (
      .cur_ptrs (st_ptrs[req_line]),
      .cur_vld  (st_vld[req_line]),
      .cur_ovf  (st_ovf[req_line]),
      .cur_rr   (st_rr[req_line]),
      .op       (op),
      .policy   (policy),
      .node     (req_node),
      .sharers  (cur_sharers),
      .nxt_ptrs (nxt_ptrs),
      .nxt_vld  (nxt_vld),
      .nxt_ovf  (nxt_ovf),
      .nxt_rr   (nxt_rr),
      .inv_mask (upd_inv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            st_ptrs[l] <= '0;
            st_vld[l]  <= '0;
            st_rr[l]   <= '0;
         end
         st_ovf    <= '0;
         inv_valid <= 1'b0;
         inv_line  <= '0;
         inv_mask  <= '0;
      end else begin
         if (do_req) begin
            st_ptrs[req_line] <= nxt_ptrs;
            st_vld[req_line]  <= nxt_vld;
            st_ovf[req_line]  <= nxt_ovf;
            st_rr[req_line]   <= nxt_rr;
         end
         inv_valid <= do_req && (upd_inv != '0);
         inv_mask  <= do_req ? upd_inv : '0;
         inv_line  <= req_line;
      end
   end

   // R3: outside no-broadcast mode a read never triggers invalidation.
   p_read_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_READ && policy != POL_NOBC) |=> !inv_valid);

   // R4: a no-broadcast read displaces at most one sharer.
   p_single_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_READ && policy == POL_NOBC) |=> $onehot0(inv_mask));

   p_writer_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_WRITE) |=> !inv_mask[$past(req_node)]);

   p_write_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_WRITE) |=>
         (!st_ovf[$past(req_line)] && st_vld[$past(req_line)] == NPTR'(1)));

   p_evict_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_EVICT) |=>
         (!st_ovf[$past(req_line)] && st_vld[$past(req_line)] == '0));

   p_no_req_no_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!inv_valid && inv_mask == '0));

endmodule

// File: tb/test_dir_limited_ptr.sv
`timescale 1ns/1ps
module test_dir_limited_ptr;
   localparam int NODES = 16;
   localparam int NPTR  = 2;
   localparam int LINES = 4;
   localparam int GRP   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_policy = 2'd0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd3;
   logic [1:0]  req_line = '0;
   logic [3:0]  req_node = '0;
   logic        inv_valid;
   logic [1:0]  inv_line;
   logic [15:0] inv_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int       m_slot [LINES][NPTR];
   bit       m_ovf  [LINES];
   bit [7:0] m_vec  [LINES];
   int       m_rr   [LINES];

   always #2.5 clk = ~clk;

   dir_limited_ptr #(.NODES(NODES), .NPTR(NPTR), .LINES(LINES)) i_dir_limited_ptr (
      .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy),
      .req_valid(req_valid), .req_op(req_op), .req_line(req_line), .req_node(req_node),
      .inv_valid(inv_valid), .inv_line(inv_line), .inv_mask(inv_mask)
   );

   function automatic void model_clear(int ln);
      for (int p = 0; p < NPTR; p++) m_slot[ln][p] = -1;
      m_ovf[ln] = 1'b0;
      m_vec[ln] = '0;
      m_rr[ln]  = 0;
   endfunction

   function automatic logic [15:0] model_sharers(int ln, int pl);
      logic [15:0] s = '0;
      if (!m_ovf[ln]) begin
         for (int p = 0; p < NPTR; p++) if (m_slot[ln][p] >= 0) s[m_slot[ln][p]] = 1'b1;
      end else if (pl == 2) begin
         for (int n = 0; n < NODES; n++) s[n] = m_vec[ln][n / GRP];
      end else begin
         s = 16'hFFFF;
      end
      return s;
   endfunction

   // Requirement-level model: returns the mask expected one cycle later.
   function automatic logic [15:0] model_step(int ln, int op, int nd, int pl);
      logic [15:0] sh = model_sharers(ln, pl);
      logic [15:0] m = '0;
      case (op)
         0: begin
            if (!m_ovf[ln]) begin
               bit hit = 1'b0;
               int fr = -1;
               for (int p = 0; p < NPTR; p++) begin
                  if (m_slot[ln][p] == nd) hit = 1'b1;
                  if (m_slot[ln][p] < 0 && fr < 0) fr = p;
               end
               if (!hit) begin
                  if (fr >= 0) m_slot[ln][fr] = nd;
                  else if (pl == 1) begin
                     m[m_slot[ln][m_rr[ln]]] = 1'b1;
                     m_slot[ln][m_rr[ln]] = nd;
                     m_rr[ln] = (m_rr[ln] + 1) % NPTR;
                  end else if (pl == 2) begin
                     m_vec[ln] = '0;
                     for (int p = 0; p < NPTR; p++) m_vec[ln][m_slot[ln][p] / GRP] = 1'b1;
                     m_vec[ln][nd / GRP] = 1'b1;
                     m_ovf[ln] = 1'b1;
                  end else m_ovf[ln] = 1'b1;
               end
            end else if (pl == 2) m_vec[ln][nd / GRP] = 1'b1;
         end
         1: begin
            m = sh;
            m[nd] = 1'b0;
            model_clear(ln);
            m_slot[ln][0] = nd;
         end
         2: begin
            m = sh;
            model_clear(ln);
         end
         default: ;
      endcase
      return m;
   endfunction

   task automatic check_out(logic [15:0] exp_mask, int exp_line, bit line_chk, string tag);
      checks++;
      if (inv_valid !== (exp_mask != 0) || inv_mask !== exp_mask ||
          (line_chk && exp_mask != 0 && inv_line !== 2'(exp_line))) begin
         fails++;
         $display("FAIL %s: valid=%0b mask=%h line=%0d expected valid=%0b mask=%h line=%0d",
                  tag, inv_valid, inv_mask, inv_line, exp_mask != 0, exp_mask, exp_line);
      end
   endtask

   // Called at a falling edge; drives, waits one cycle, compares.
   task automatic do_req(int ln, int op, int nd, string tag);
      logic [15:0] e;
      req_valid = 1'b1;
      req_op    = 2'(op);
      req_line  = 2'(ln);
      req_node  = 4'(nd);
      e = model_step(ln, op, nd, cfg_policy);
      @(negedge clk);
      check_out(e, ln, 1'b1, tag);
   endtask

   task automatic do_idle(string tag);
      req_valid = 1'b0;
      req_op    = 2'($urandom_range(0, 3));
      @(negedge clk);
      check_out(16'h0, 0, 1'b0, tag);
   endtask

   task automatic do_reset(int pl);
      req_valid  = 1'b0;
      rst_n      = 1'b0;
      cfg_policy = 2'(pl);
      for (int l = 0; l < LINES; l++) model_clear(l);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_out(16'h0, 0, 1'b0, "R1 reset");
   endtask

   initial begin
      @(negedge clk);
      for (int pl = 0; pl < 4; pl++) begin
         string ovt;
         ovt = (pl == 1) ? "R4" : (pl == 2) ? "R5" : "R3";
         do_reset(pl);
         do_req(1, 1, 5, "R1 write to empty line");
         do_req(0, 0, 3, "R2 first reader");
         do_req(0, 0, 7, "R2 second reader");
         do_req(0, 0, 3, "R2 repeat reader");
         do_req(0, 3, 4, "R2 idle op");
         do_req(0, 0, 9, {ovt, " overflow read"});
         do_req(0, 0, 12, {ovt, " read after overflow"});
         do_req(0, 0, 13, {ovt, " further read"});
         do_req(0, 1, 7, "R6 write excludes writer");
         do_req(0, 1, 2, "R7 second write");
         do_req(0, 0, 4, "R2 reader after write");
         do_req(0, 2, 0, "R8 evict");
         do_req(0, 1, 6, "R8 entry empty after evict");
         do_idle("R9 quiet cycle");
         do_req(2, 0, 1, "R10 other line read");
         do_req(3, 1, 0, "R10 untouched line write");
         do_req(2, 1, 1, "R6 sole sharer writes");
         do_req(1, 2, 0, "R8 evict sole writer");
         for (int i = 0; i < 500; i++) begin
            int r = $urandom_range(0, 19);
            if (r == 0) do_idle("R9 random idle");
            else do_req($urandom_range(0, LINES - 1),
                        (r < 12) ? 0 : (r < 17) ? 1 : (r < 19) ? 2 : 3,
                        $urandom_range(0, NODES - 1), "R10 random traffic");
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule